// File: doc/BRIEF.md
# Burst-Capable Wishbone Memory Slave

This block is an on-chip synchronous memory behind a Wishbone slave port with registered-feedback bursts. A bus master can do classic single reads and writes. It can also run incrementing bursts, in which the slave acknowledges one beat on every clock. During a burst the slave works out the address of the following beat on its own, linear or wrapping on a 4, 8 or 16 word boundary, and it starts the array read for that beat before the master presents it. Read data is therefore valid in the same cycle as each acknowledge.

The storage is `SIZE` granules of `GRAN_W` bits, organised as words of `DATA_W` bits. `SIZE` must be a power of two and no smaller than the number of lanes per word. Elaboration stops with an error for any other value. Setting `WRITABLE` to 0 gives a read-only variant. Its contents stay at the all-zero initial image, while writes are still acknowledged. The port is a bus-slave handshake (request with cyc/stb, answer with ack), so no valid/ready stream rules apply. The master holds its request until it sees ack, and that is the only back-pressure.

Top module: `wbsram_burst`

## Requirements
- R1: In the first cycle of a new request (cyc_i and stb_i both high, after a cycle in which ack_o was low or the request was absent), ack_o is low. If the request is still held, ack_o is high in the next cycle.
- R2: A classic access (cti_i other than 3'b010) that keeps its request high after the acknowledge starts a new access. Ack_o is then low for one cycle and high in the following one, so a held request is acknowledged every second cycle.
- R3: While cti_i is 3'b010 (incrementing) in an acknowledged cycle and the request stays high, ack_o is high again in the next cycle. The result is one beat per clock, for reads and for writes.
- R4: With bte_i = 2'b00 (linear), the next beat reads the word at the presented address plus one, modulo the word depth.
- R5: With bte_i = 2'b01, 2'b10 or 2'b11, only the low 2, 3 or 4 address bits increment, modulo 4, 8 or 16, and the upper bits are held. For example, wrap-4 from address 13 gives 13, 14, 15, 12, 13, and so on.
- R6: When cti_i is 3'b111 (end of burst) in an acknowledged cycle, ack_o is low in the next cycle.
- R7: A write takes effect in its acknowledged cycle. Lane l (bits [l*GRAN_W +: GRAN_W]) of the addressed word takes dat_i's lane l only when sel_i[l] is 1. The other lanes keep their contents.
- R8: In every acknowledged read cycle, dat_o carries the full word at the presented address, whatever the value of sel_i.
- R9: With WRITABLE = 0, writes are acknowledged with the same timing but leave the memory unchanged, and every read returns zero.
- R10: Ack_o is never high in a cycle where cyc_i or stb_i is low. A request that returns after such a gap is treated as new (R1), even in the middle of a burst.
- R11: After reset, ack_o is low and every word reads as zero until it is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Strobe, this slave addressed |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | AW | Word address; AW = log2(SIZE*GRAN_W/DATA_W) |
| dat_i | input | DATA_W | Write data |
| sel_i | input | DATA_W/GRAN_W | Lane enables for writes |
| cti_i | input | 3 | Cycle type: 000 classic, 010 incrementing, 111 end of burst |
| bte_i | input | 2 | Burst wrap: 00 linear, 01 wrap-4, 10 wrap-8, 11 wrap-16 |
| dat_o | output | DATA_W | Read data, valid in acknowledged read cycles |
| ack_o | output | 1 | Beat acknowledge |

## Verification
Ack_o depends on the request in the current cycle and on a single register, so its expected value is known one cycle after each request beat. Read data is due in the acknowledged cycle itself: it was fetched at the previous edge from either the presented address or the internally computed next beat. A write changes what a read returns from the next access onward. The bench applies every beat at the falling edge, compares ack_o and dat_o a time unit later against a behavioural model, and only then advances the model to the state of the coming rising edge. The result is that every comparison falls in the cycle where the result is due.

// File: rtl/wbsram_pkg.sv
package wbsram_pkg;
  // cycle type codes
  localparam logic [2:0] CTI_CLASSIC = 3'b000;
  localparam logic [2:0] CTI_INCR    = 3'b010;
  localparam logic [2:0] CTI_EOB     = 3'b111;
  // burst wrap codes
  localparam logic [1:0] BTE_LIN     = 2'b00;
  localparam logic [1:0] BTE_W4      = 2'b01;
  localparam logic [1:0] BTE_W8      = 2'b10;
  localparam logic [1:0] BTE_W16     = 2'b11;
  localparam int         NUM_WRAPS   = 3;
endpackage

// File: rtl/wbsram_next_addr.sv
module wbsram_next_addr
  import wbsram_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] cur_i,
  input  logic [1:0]    bte_i,
  output logic [AW-1:0] nxt_o
);
  logic [AW-1:0] inc;
  logic [AW-1:0] wrapped [NUM_WRAPS];

  assign inc = cur_i + 1'b1;

  // one masked incrementer per wrap length: 4, 8, 16 words
  for (genvar g = 0; g < NUM_WRAPS; g++) begin : g_wrap
    localparam int LOWB = g + 2;
    localparam int KEEP = (LOWB < AW) ? LOWB : AW;
    logic [AW-1:0] mask;
    assign mask       = AW'((64'd1 << KEEP) - 64'd1);
    assign wrapped[g] = (cur_i & ~mask) | (inc & mask);
  end

  always_comb begin
    case (bte_i)
      BTE_W4:  nxt_o = wrapped[0];
      BTE_W8:  nxt_o = wrapped[1];
      BTE_W16: nxt_o = wrapped[2];
      default: nxt_o = inc;
    endcase
  end
endmodule

// File: rtl/wbsram_ctrl.sv
module wbsram_ctrl
  import wbsram_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       req_i,
  input  logic [2:0] cti_i,
  output logic       ack_o,
  output logic       stream_o
);
  logic ack_q;

  // a beat is promised after a fresh request, or after an incrementing beat
  always_ff @(posedge clk_i) begin
    if (rst_i) ack_q <= 1'b0;
    else       ack_q <= req_i & (~ack_q | (cti_i == CTI_INCR));
  end

  assign ack_o    = ack_q & req_i;
  assign stream_o = ack_o & (cti_i == CTI_INCR);
endmodule

// File: rtl/wbsram_array.sv
module wbsram_array #(
  parameter int DEPTH    = 32,
  parameter int AW       = 5,
  parameter int LANES    = 4,
  parameter int GRAN_W   = 8,
  parameter bit WRITABLE = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    wr_i,
  input  logic [AW-1:0]           waddr_i,
  input  logic [LANES*GRAN_W-1:0] wdata_i,
  input  logic [LANES-1:0]        wsel_i,
  input  logic [AW-1:0]           raddr_i,
  output logic [LANES*GRAN_W-1:0] rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [GRAN_W-1:0] mem [DEPTH];
    logic [GRAN_W-1:0] rd_q;

    initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    end

    if (WRITABLE) begin : g_wr
      always_ff @(posedge clk_i) begin
        if (wr_i && wsel_i[l]) mem[waddr_i] <= wdata_i[l*GRAN_W +: GRAN_W];
      end
    end else begin : g_ro
      logic unused_wr;
      assign unused_wr = ^{wr_i, waddr_i, wdata_i[l*GRAN_W +: GRAN_W], wsel_i[l]};
    end

    always_ff @(posedge clk_i) rd_q <= mem[raddr_i];
    assign rdata_o[l*GRAN_W +: GRAN_W] = rd_q;
  end
endmodule

// File: rtl/wbsram_burst.sv
module wbsram_burst
  import wbsram_pkg::*;
#(
  parameter int  SIZE     = 128,
  parameter int  DATA_W   = 32,
  parameter int  GRAN_W   = 8,
  parameter bit  WRITABLE = 1'b1,
  localparam int LANES    = DATA_W / GRAN_W,
  localparam int DEPTH    = (SIZE / LANES > 0) ? SIZE / LANES : 1,
  localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [AW-1:0]     adr_i,
  input  logic [DATA_W-1:0] dat_i,
  input  logic [LANES-1:0]  sel_i,
  input  logic [2:0]        cti_i,
  input  logic [1:0]        bte_i,
  output logic [DATA_W-1:0] dat_o,
  output logic              ack_o
);
  if (SIZE <= 0 || (SIZE & (SIZE - 1)) != 0) begin : g_bad_size
    $error("wbsram_burst: SIZE must be a power of two");
  end
  if (SIZE < LANES) begin : g_bad_ratio
    $error("wbsram_burst: SIZE below lanes per word");
  end
  if (DATA_W % GRAN_W != 0) begin : g_bad_gran
    $error("wbsram_burst: DATA_W not a multiple of GRAN_W");
  end

  logic          req;
  logic          stream;
  logic [AW-1:0] nxt_addr;
  logic [AW-1:0] rd_addr;

  assign req = cyc_i & stb_i;

  wbsram_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .req_i    (req),
    .cti_i    (cti_i),
    .ack_o    (ack_o),
    .stream_o (stream)
  );

  wbsram_next_addr #(.AW(AW)) u_next (
    .cur_i (adr_i),
    .bte_i (bte_i),
    .nxt_o (nxt_addr)
  );

  // prefetch the coming beat while the current one is acknowledged
  assign rd_addr = stream ? nxt_addr : adr_i;

  wbsram_array #(
    .DEPTH    (DEPTH),
    .AW       (AW),
    .LANES    (LANES),
    .GRAN_W   (GRAN_W),
    .WRITABLE (WRITABLE)
  ) u_array (
    .clk_i   (clk_i),
    .wr_i    (ack_o & we_i),
    .waddr_i (adr_i),
    .wdata_i (dat_i),
    .wsel_i  (sel_i),
    .raddr_i (rd_addr),
    .rdata_o (dat_o)
  );
endmodule

// File: rtl/wbsram_burst_chk.sv
module wbsram_burst_chk (
  input logic       clk_i,
  input logic       rst_i,
  input logic       cyc_i,
  input logic       stb_i,
  input logic [2:0] cti_i,
  input logic       ack_o
);
  logic req;
  assign req = cyc_i & stb_i;

  AST_ACK_AFTER_FIRST: assert property (@(posedge clk_i) disable iff (rst_i)
    (req && !ack_o) |=> (ack_o || !req)); // R1

  AST_BURST_STREAMS: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_o && cti_i == 3'b010) |=> (ack_o || !req)); // R3

  AST_NON_INCR_RELEASES: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_o && cti_i != 3'b010) |=> !ack_o); // R6

  AST_RESTART_IS_NEW: assert property (@(posedge clk_i) disable iff (rst_i)
    (!req ##1 req) |-> !ack_o); // R10
endmodule

bind wbsram_burst wbsram_burst_chk u_chk (
  .clk_i (clk_i),
  .rst_i (rst_i),
  .cyc_i (cyc_i),
  .stb_i (stb_i),
  .cti_i (cti_i),
  .ack_o (ack_o)
);

// File: tb/wbsram_burst_tb_top.sv
module wbsram_burst_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SIZE  = 128;
  localparam int DW    = 32;
  localparam int GW    = 8;
  localparam int LN    = DW / GW;
  localparam int DEPTH = SIZE / LN;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [2:0] C_CLS = 3'b000;
  localparam logic [2:0] C_INC = 3'b010;
  localparam logic [2:0] C_END = 3'b111;

  logic clk = 1'b0;
  logic rst;
  logic cyc, stb, we;
  logic [AW-1:0] adr;
  logic [DW-1:0] dat;
  logic [LN-1:0] sel;
  logic [2:0]    cti;
  logic [1:0]    bte;
  logic [DW-1:0] dat_rw, dat_ro;
  logic          ack_rw, ack_ro;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wbsram_burst #(.SIZE(SIZE), .DATA_W(DW), .GRAN_W(GW), .WRITABLE(1'b1)) dut_i (
    .clk_i(clk), .rst_i(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we), .adr_i(adr),
    .dat_i(dat), .sel_i(sel), .cti_i(cti), .bte_i(bte), .dat_o(dat_rw), .ack_o(ack_rw));

  wbsram_burst #(.SIZE(SIZE), .DATA_W(DW), .GRAN_W(GW), .WRITABLE(1'b0)) ro_i (
    .clk_i(clk), .rst_i(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we), .adr_i(adr),
    .dat_i(dat), .sel_i(sel), .cti_i(cti), .bte_i(bte), .dat_o(dat_ro), .ack_o(ack_ro));

  // behavioural reference
  logic [DW-1:0] mdl [DEPTH];
  bit    pend;
  int    errors = 0;
  int    checks = 0;
  string tag = "R11";

  task automatic check(string rq, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] step_addr(logic [AW-1:0] a, logic [1:0] b);
    int n;
    case (b)
      2'b00:   return a + 1'b1;
      2'b01:   n = 4;
      2'b10:   n = 8;
      default: n = 16;
    endcase
    return (a & ~AW'(n - 1)) | ((a + 1'b1) & AW'(n - 1));
  endfunction

  // one bus cycle: drive at falling edge, compare, advance model
  task automatic beat(bit c, bit s, bit w, logic [AW-1:0] a, logic [DW-1:0] d,
                      logic [LN-1:0] sl, logic [2:0] ct, logic [1:0] bt);
    bit req, eack;
    cyc = c; stb = s; we = w; adr = a; dat = d; sel = sl; cti = ct; bte = bt;
    #1;
    req  = c && s;
    eack = req && pend;
    check(tag,  "ack", {31'b0, ack_rw}, {31'b0, eack});
    check("R9", "ro ack", {31'b0, ack_ro}, {31'b0, eack});
    if (eack && !w) begin
      check(tag,  "rdata", dat_rw, mdl[a]);
      check("R9", "ro rdata", dat_ro, '0);
    end
    if (eack && w)
      for (int l = 0; l < LN; l++)
        if (sl[l]) mdl[a][l*GW +: GW] = d[l*GW +: GW];
    pend = req && (!eack || ct == C_INC);
    @(negedge clk);
  endtask

  task automatic idle();
    beat(0, 0, 0, '0, '0, '0, C_CLS, 2'b00);
  endtask

  task automatic single(bit w, logic [AW-1:0] a, logic [DW-1:0] d, logic [LN-1:0] sl);
    beat(1, 1, w, a, d, sl, C_CLS, 2'b00);
    beat(1, 1, w, a, d, sl, C_CLS, 2'b00);
    idle();
  endtask

  task automatic burst(bit w, logic [AW-1:0] start, int count, logic [1:0] bt, logic [DW-1:0] base);
    logic [AW-1:0] a;
    a = start;
    beat(1, 1, w, a, base, '1, C_INC, bt);
    for (int j = 0; j < count; j++) begin
      beat(1, 1, w, a, base + DW'(j) * 32'h0001_0003, '1,
           (j == count - 1) ? C_END : C_INC, bt);
      a = step_addr(a, bt);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    pend = 0;
    rst = 1'b1; cyc = 0; stb = 0; we = 0; adr = '0; dat = '0; sel = '0; cti = C_CLS; bte = 2'b00;
    repeat (3) @(negedge clk);
    #1 check("R11", "ack in reset", {31'b0, ack_rw}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R11: idle after reset, memory reads zero
    tag = "R11";
    idle(); idle();
    single(0, 5'd3, '0, 4'hf);
    single(0, 5'd31, '0, 4'hf);

    // R1 / R7: fill every word with classic writes
    tag = "R1";
    for (int i = 0; i < DEPTH; i++) single(1, AW'(i), 32'hA000_0000 + i * 32'h0101_0101, 4'hf);
    tag = "R7";
    single(1, 5'd5, 32'h5aa5_c33c, 4'b0001);
    single(1, 5'd6, 32'h1234_5678, 4'b1010);
    single(1, 5'd7, 32'hffff_ffff, 4'b0000);

    // R8: read back with various sel values
    tag = "R8";
    single(0, 5'd5, '0, 4'b0000);
    single(0, 5'd6, '0, 4'b0001);
    single(0, 5'd7, '0, 4'b1000);

    // R2: held classic request acknowledged every second cycle
    tag = "R2";
    for (int k = 0; k < 6; k++) beat(1, 1, 0, 5'd9, '0, '0, C_CLS, 2'b00);
    idle();

    // R4: linear burst across the top of memory
    tag = "R4";
    burst(0, 5'd28, 8, 2'b00, '0); idle();

    // R5: wrap bursts
    tag = "R5";
    burst(0, 5'd13, 8, 2'b01, '0);  idle();
    burst(0, 5'd22, 16, 2'b10, '0); idle();
    burst(0, 5'd22, 32, 2'b11, '0); idle();

    // R3: write burst at one beat per clock, then read back
    tag = "R3";
    burst(1, 5'd3, 8, 2'b10, 32'h00c0_0000); idle();
    burst(0, 5'd0, 12, 2'b00, '0); idle();

    // R6: end of burst followed straight by a new access
    tag = "R6";
    burst(0, 5'd17, 1, 2'b00, '0);
    burst(0, 5'd2, 4, 2'b01, '0);
    single(0, 5'd4, '0, 4'hf);

    // R10: request drops mid-burst, then restarts
    tag = "R10";
    beat(1, 1, 0, 5'd10, '0, '1, C_INC, 2'b00);
    beat(1, 1, 0, 5'd10, '0, '1, C_INC, 2'b00);
    beat(1, 1, 0, 5'd11, '0, '1, C_INC, 2'b00);
    beat(1, 0, 0, 5'd12, '0, '1, C_INC, 2'b00);
    burst(0, 5'd20, 4, 2'b00, '0);
    beat(0, 1, 0, 5'd24, '0, '1, C_INC, 2'b00);
    burst(0, 5'd26, 3, 2'b00, '0);
    idle();

    // R9 is checked on every cycle above; final read-only write attempt
    tag = "R9";
    single(1, 5'd1, 32'hdead_beef, 4'hf);
    single(0, 5'd1, '0, 4'hf);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule